// File: doc/BRIEF.md
# Self-Repairing Signed-Digit Adder Controller

This block adds two radix-2 signed-digit operands on a small self-checking adder. It then repairs the result when the adder, its checkers or its input lines are hit by a stuck-at or long transient fault. Each digit is a pair of bits (neg, pos) and has the value pos - neg, so (0,0) and (1,1) both stand for zero. The adder is built only from full adders. Every full adder checks itself by testing whether its sum and carry agree with the equality of its three inputs. Parity checks guard the operand lines.

A controller first runs the addition on the operands as given. If no checker complains, it returns that result. Otherwise it runs the addition once more with every operand bit inverted. A full adder is a self-dual function, so this second pass masks any single stuck line. Inverting the recomputed result gives the corrected sum. The controller also compares the two passes and the latched flags to classify the event and to name the faulty digit. A parameter selects one of two parity schemes: a single parity check over both whole operands, with the faulty digit found by comparing the two passes, or one check per digit, with the faulty digit read from the flag that fired. A fault mask port forces any chosen internal line to a chosen value, so the repair path can be exercised.

Top module: `sd_selfrepair_add`

## Requirements
- R1: While reset is low and after its release, done is 0 and status, fault_idx, sum_pos and sum_neg are all 0.
- R2: Digit i of an operand or of the sum is (neg[i], pos[i]) with value pos[i]-neg[i], weight 2^i; both (0,0) and (1,1) mean zero. The N+1 digit sum equals A+B whenever status is 0, 1, 2 or 3.
- R3: A start sampled in idle with no checker flag raised gives a one-cycle done pulse on the second rising edge after the sampling edge, with status 0 (ok) and fault_idx 0.
- R4: If any flag is raised in the first pass, the addition is recomputed with every operand bit inverted, and done pulses on the third rising edge after the sampling edge. If the recomputation raises no flag, the sum is the bitwise inverse of the recomputed result.
- R5: If the first pass raised an adder flag and the recomputation is clean, status is 1 and fault_idx is the lowest digit whose adder flag was set. Adder flags take precedence over parity flags.
- R6: With whole-operand parity (PER_DIGIT_PAR=0), a parity-only first-pass error followed by a clean recomputation gives status 2. fault_idx is then the lowest digit position where the first and recomputed results agree in at least one of the two bits.
- R7: With per-digit parity (PER_DIGIT_PAR=1), the same event gives status 2, and fault_idx is the lowest digit whose parity flag fired in the first pass.
- R8: If the recomputation raises a flag again and the first result is the exact bitwise complement of the second, status is 3 (checker failure), the sum is the first result and fault_idx is 0.
- R9: If the recomputation raises a flag again and the results are not complementary, status is 4 (multiple faults) and fault_idx is 0.
- R10: start is ignored unless the controller is idle; a start during a recomputation neither alters the pending result nor starts a new operation.
- R11: Bit 8*d+k of flt_mask forces line k of digit d to bit 8*d+k of flt_val. The line codes are k=0 a pos, 1 a neg, 2 b pos, 3 b neg, 4 first-stage sum, 5 first-stage carry out, 6 second-stage sum, 7 the digit's adder flag. A forced line that already holds its forced value has no effect. a_par[d] and b_par[d] carry pos^neg of each operand digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an addition (honoured only when idle) |
| a_pos | input | N | Operand A positive bits |
| a_neg | input | N | Operand A negative bits |
| b_pos | input | N | Operand B positive bits |
| b_neg | input | N | Operand B negative bits |
| a_par | input | N | Reference parity of each A digit |
| b_par | input | N | Reference parity of each B digit |
| flt_mask | input | 8*N | Fault-forcing enables, one per internal line |
| flt_val | input | 8*N | Forced values for the enabled lines |
| done | output | 1 | One-cycle result strobe |
| status | output | 3 | 0 ok, 1 adder fault, 2 input fault, 3 checker failure, 4 multiple faults |
| fault_idx | output | clog2(N+1) | Located faulty digit |
| sum_pos | output | N+1 | Sum positive bits |
| sum_neg | output | N+1 | Sum negative bits |

## Verification
The bench builds two copies with N=8 that share every input, one with whole-operand parity and one with per-digit parity. The same forced fault can therefore be checked against both localization rules. Eight digits leave room for faults in the lowest digit, in a middle digit and in the top digit, whose carry feeds only the extra ninth sum digit. They also allow two adder faults at separate positions, which exercises the precedence rule. A behavioural model of each full-adder stage chooses forced values that are certain to flip the line, and a forced value equal to the line's own value checks that an inactive fault is harmless.

// File: rtl/sd_selfrepair_add.sv
module sd_chk_adder #(
  parameter int N = 8,
  parameter bit PER_DIGIT_PAR = 1'b0
) (
  input  logic           inv,
  input  logic [N-1:0]   ap,
  input  logic [N-1:0]   an,
  input  logic [N-1:0]   bp,
  input  logic [N-1:0]   bn,
  input  logic [N-1:0]   apar,
  input  logic [N-1:0]   bpar,
  input  logic [8*N-1:0] fmask,
  input  logic [8*N-1:0] fval,
  output logic [N:0]     zp,
  output logic [N:0]     zn,
  output logic [N-1:0]   add_err,
  output logic [N-1:0]   par_err
);
  localparam bit NODD = N % 2;

  logic [N-1:0] xap, xan, xbp, xbn;
  logic [N-1:0] lap, lan, lbp, lbn;
  logic [N-1:0] s0, s, hc, u0, u, tc;
  logic [N:0]   h, t;

  assign xap = ap ^ {N{inv}};
  assign xan = an ^ {N{inv}};
  assign xbp = bp ^ {N{inv}};
  assign xbn = bn ^ {N{inv}};
  assign h[0] = inv;
  assign t[0] = ~inv;

  for (genvar i = 0; i < N; i++) begin : g_dig
    localparam int B = 8 * i;
    logic eq1, eq2, fe1, fe2;
    assign lap[i] = fmask[B]   ? fval[B]   : xap[i];
    assign lan[i] = fmask[B+1] ? fval[B+1] : xan[i];
    assign lbp[i] = fmask[B+2] ? fval[B+2] : xbp[i];
    assign lbn[i] = fmask[B+3] ? fval[B+3] : xbn[i];

    assign {hc[i], s0[i]} = {1'b0, lap[i]} + {1'b0, ~lan[i]} + {1'b0, lbp[i]};
    assign s[i]   = fmask[B+4] ? fval[B+4] : s0[i];
    assign h[i+1] = fmask[B+5] ? fval[B+5] : hc[i];

    assign {tc[i], u0[i]} = {1'b0, s[i]} + {1'b0, h[i]} + {1'b0, ~lbn[i]};
    assign u[i]   = fmask[B+6] ? fval[B+6] : u0[i];
    assign t[i+1] = tc[i];

    assign eq1 = (lap[i] == ~lan[i]) && (~lan[i] == lbp[i]);
    assign eq2 = (s[i] == h[i]) && (h[i] == ~lbn[i]);
    assign fe1 = eq1 ^ (s[i] ~^ h[i+1]);
    assign fe2 = eq2 ^ (u[i] ~^ t[i+1]);
    assign add_err[i] = fmask[B+7] ? fval[B+7] : (fe1 | fe2);

    assign zp[i] = u[i];
    assign zn[i] = ~t[i];
  end

  assign zp[N] = t[N];
  assign zn[N] = ~h[N];

  if (PER_DIGIT_PAR) begin : g_ip
    assign par_err = (lap ^ lan ^ apar) | (lbp ^ lbn ^ bpar);
  end else begin : g_pp
    logic pe;
    assign pe = (^apar) ^ (^bpar) ^ (^s) ^ (^lbn) ^ NODD;
    if (N > 1) begin : g_pad
      assign par_err = {{(N-1){1'b0}}, pe};
    end else begin : g_one
      assign par_err = pe;
    end
  end
endmodule

module sd_selfrepair_add #(
  parameter int N = 8,
  parameter bit PER_DIGIT_PAR = 1'b0,
  localparam int IW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   a_pos,
  input  logic [N-1:0]   a_neg,
  input  logic [N-1:0]   b_pos,
  input  logic [N-1:0]   b_neg,
  input  logic [N-1:0]   a_par,
  input  logic [N-1:0]   b_par,
  input  logic [8*N-1:0] flt_mask,
  input  logic [8*N-1:0] flt_val,
  output logic           done,
  output logic [2:0]     status,
  output logic [IW-1:0]  fault_idx,
  output logic [N:0]     sum_pos,
  output logic [N:0]     sum_neg
);
  localparam logic [2:0] S_OK = 3'd0, S_ADD = 3'd1, S_INP = 3'd2, S_CHK = 3'd3, S_MULT = 3'd4;

  typedef enum logic [1:0] {IDLE, FIRST, RECOMP, REPORT} st_t;
  st_t st;

  logic [N-1:0] op_ap, op_an, op_bp, op_bn, op_apar, op_bpar;
  logic [N:0]   zp, zn, zf_p, zf_n, eqpos;
  logic [N-1:0] add_err, par_err, aerr_f, perr_f;
  logic         flag;

  sd_chk_adder #(.N(N), .PER_DIGIT_PAR(PER_DIGIT_PAR)) u_add (
    .inv(st == RECOMP), .ap(op_ap), .an(op_an), .bp(op_bp), .bn(op_bn),
    .apar(op_apar), .bpar(op_bpar), .fmask(flt_mask), .fval(flt_val),
    .zp(zp), .zn(zn), .add_err(add_err), .par_err(par_err)
  );

  assign flag  = (|add_err) | (|par_err);
  assign eqpos = ~(zf_p ^ zp) | ~(zf_n ^ zn);
  assign done  = (st == REPORT);

  function automatic logic [IW-1:0] low_idx(input logic [N:0] v);
    low_idx = '0;
    for (int i = N; i >= 0; i--)
      if (v[i]) low_idx = IW'(i);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      {op_ap, op_an, op_bp, op_bn, op_apar, op_bpar} <= '0;
      {zf_p, zf_n, aerr_f, perr_f} <= '0;
      status <= S_OK;
      fault_idx <= '0;
      sum_pos <= '0;
      sum_neg <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          op_ap <= a_pos; op_an <= a_neg; op_bp <= b_pos; op_bn <= b_neg;
          op_apar <= a_par; op_bpar <= b_par;
          st <= FIRST;
        end
        FIRST: begin
          zf_p <= zp; zf_n <= zn;
          aerr_f <= add_err; perr_f <= par_err;
          if (!flag) begin
            sum_pos <= zp; sum_neg <= zn;
            status <= S_OK; fault_idx <= '0;
            st <= REPORT;
          end else st <= RECOMP;
        end
        RECOMP: begin
          if (flag) begin
            status <= ({zf_p, zf_n} == ~{zp, zn}) ? S_CHK : S_MULT;
            sum_pos <= zf_p; sum_neg <= zf_n;
            fault_idx <= '0;
          end else begin
            sum_pos <= ~zp; sum_neg <= ~zn;
            if (|aerr_f) begin
              status <= S_ADD;
              fault_idx <= low_idx({1'b0, aerr_f});
            end else begin
              status <= S_INP;
              fault_idx <= PER_DIGIT_PAR ? low_idx({1'b0, perr_f}) : low_idx(eqpos);
            end
          end
          st <= REPORT;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_recomp_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FIRST && flag) |=> st == RECOMP);
  a_r3_clean_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FIRST && !flag) |=> (done && status == S_OK));
  a_r2_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status <= S_MULT);
  a_r8_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status == S_OK || status == S_CHK || status == S_MULT)) |-> fault_idx == '0);
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int'(fault_idx) <= N);
  a_r10_ops_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FIRST || st == RECOMP) |=> $stable(op_ap) && $stable(op_bn));
endmodule

// File: tb/sd_selfrepair_add_test.sv
module sd_selfrepair_add_test;
  localparam int N = 8;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] ap_i = '0, an_i = '0, bp_i = '0, bn_i = '0, apar = '0, bpar = '0;
  logic [8*N-1:0] fm = '0, fv = '0;
  logic done_a, done_b;
  logic [2:0] st_a, st_b;
  logic [IW-1:0] idx_a, idx_b;
  logic [N:0] sp_a, sn_a, sp_b, sn_b;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sd_selfrepair_add #(.N(N), .PER_DIGIT_PAR(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_pos(ap_i), .a_neg(an_i),
    .b_pos(bp_i), .b_neg(bn_i), .a_par(apar), .b_par(bpar), .flt_mask(fm), .flt_val(fv),
    .done(done_a), .status(st_a), .fault_idx(idx_a), .sum_pos(sp_a), .sum_neg(sn_a));

  sd_selfrepair_add #(.N(N), .PER_DIGIT_PAR(1'b1)) uut_ip (
    .clk(clk), .rst_n(rst_n), .start(start), .a_pos(ap_i), .a_neg(an_i),
    .b_pos(bp_i), .b_neg(bn_i), .a_par(apar), .b_par(bpar), .flt_mask(fm), .flt_val(fv),
    .done(done_b), .status(st_b), .fault_idx(idx_b), .sum_pos(sp_b), .sum_neg(sn_b));

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int sdv(input logic [N:0] p, input logic [N:0] n);
    int r = 0;
    for (int i = 0; i <= N; i++) r += (int'(p[i]) - int'(n[i])) * (1 << i);
    return r;
  endfunction

  function automatic void fmodel(input logic [N-1:0] ap, an, bp, bn,
                                 output logic [N-1:0] s, ho, u);
    int hin = 0;
    for (int i = 0; i < N; i++) begin
      int x, y;
      x = int'(ap[i]) + int'(!an[i]) + int'(bp[i]);
      s[i] = x[0];
      ho[i] = x[1];
      y = int'(s[i]) + hin + int'(!bn[i]);
      u[i] = y[0];
      hin = int'(ho[i]);
    end
  endfunction

  task automatic run_op(input logic [N-1:0] ap, an, bp, bn,
                        input logic [8*N-1:0] m, v,
                        input int lat, input int est, input int ipp, input int iip,
                        input bit csum, input bit poke, input string tag);
    int want = sdv({1'b0, ap}, {1'b0, an}) + sdv({1'b0, bp}, {1'b0, bn});
    ap_i = ap; an_i = an; bp_i = bp; bn_i = bn;
    apar = ap ^ an; bpar = bp ^ bn;
    fm = m; fv = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(done_a == (k == lat), {tag, " R3 R4 done timing (pp)"}, int'(done_a), int'(k == lat));
      chk(done_b == (k == lat), {tag, " R3 R4 done timing (ip)"}, int'(done_b), int'(k == lat));
      if (k == lat) begin
        chk(int'(st_a) == est, {tag, " status (pp)"}, int'(st_a), est);
        chk(int'(st_b) == est, {tag, " status (ip)"}, int'(st_b), est);
        chk(int'(idx_a) == ipp, {tag, " fault_idx (pp)"}, int'(idx_a), ipp);
        chk(int'(idx_b) == iip, {tag, " fault_idx (ip)"}, int'(idx_b), iip);
        if (csum) begin
          chk(sdv(sp_a, sn_a) == want, {tag, " R2 sum value (pp)"}, sdv(sp_a, sn_a), want);
          chk(sdv(sp_b, sn_b) == want, {tag, " R2 sum value (ip)"}, sdv(sp_b, sn_b), want);
        end
      end
      if (poke && k == 1) begin
        start = 1'b1; ap_i = ~ap; bn_i = ~bn;
      end
      if (poke && k == 2) begin
        start = 1'b0; ap_i = ap; bn_i = bn;
      end
    end
    fm = '0; fv = '0;
  endtask

  logic [N-1:0] ra, rb, rc, rd, ms, mh, mu;
  logic [8*N-1:0] m, v;

  initial begin
    repeat (3) @(negedge clk);
    chk(!done_a && !done_b, "R1 done low in reset", int'(done_a | done_b), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_a == 0 && st_b == 0, "R1 status after reset", int'(st_a | st_b), 0);
    chk(idx_a == 0 && idx_b == 0, "R1 fault_idx after reset", int'(idx_a | idx_b), 0);
    chk(sp_a == 0 && sn_a == 0 && sp_b == 0 && sn_b == 0, "R1 sum after reset",
        int'(sp_a | sn_a | sp_b | sn_b), 0);

    void'($urandom(7));
    for (int k = 0; k < 6; k++) begin
      ra = N'($urandom); rb = N'($urandom); rc = N'($urandom); rd = N'($urandom);
      run_op(ra, rb, rc, rd, '0, '0, 1, 0, 0, 0, 1'b1, 1'b0, "R2 R3 clean");
    end
    run_op('1, '1, 8'h0F, 8'h00, '0, '0, 1, 0, 0, 0, 1'b1, 1'b0, "R2 zero-as-11");
    run_op('1, '0, '1, '0, '0, '0, 1, 0, 0, 0, 1'b1, 1'b0, "R2 max");
    run_op('0, '1, '0, '1, '0, '0, 1, 0, 0, 0, 1'b1, 1'b0, "R2 min");

    ra = 8'hA5; rb = 8'h18; rc = 8'h3C; rd = 8'h41;
    fmodel(ra, rb, rc, rd, ms, mh, mu);
    m = '0; v = '0; m[8*2+0] = 1'b1; v[8*2+0] = ra[2];
    run_op(ra, rb, rc, rd, m, v, 1, 0, 0, 0, 1'b1, 1'b0, "R11 inactive fault");

    m = '0; v = '0; m[8*3+4] = 1'b1; v[8*3+4] = ~ms[3];
    run_op(ra, rb, rc, rd, m, v, 2, 1, 3, 3, 1'b1, 1'b0, "R4 R5 sum line digit3");
    m = '0; v = '0; m[8*(N-1)+5] = 1'b1; v[8*(N-1)+5] = ~mh[N-1];
    run_op(ra, rb, rc, rd, m, v, 2, 1, N-1, N-1, 1'b1, 1'b0, "R5 top carry");
    m = '0; v = '0; m[8*0+6] = 1'b1; v[8*0+6] = ~mu[0];
    run_op(ra, rb, rc, rd, m, v, 2, 1, 0, 0, 1'b1, 1'b0, "R5 second stage digit0");
    m = '0; v = '0; m[8*5+4] = 1'b1; v[8*5+4] = ~ms[5]; m[8*2+4] = 1'b1; v[8*2+4] = ~ms[2];
    run_op(ra, rb, rc, rd, m, v, 2, 1, 2, 2, 1'b1, 1'b0, "R5 priority lowest");

    m = '0; v = '0; m[8*4+0] = 1'b1; v[8*4+0] = ~ra[4];
    run_op(ra, rb, rc, rd, m, v, 2, 2, 4, 4, 1'b1, 1'b0, "R6 R7 a pos digit4");
    m = '0; v = '0; m[8*0+3] = 1'b1; v[8*0+3] = ~rd[0];
    run_op(ra, rb, rc, rd, m, v, 2, 2, 0, 0, 1'b1, 1'b0, "R6 R7 b neg digit0");
    m = '0; v = '0; m[8*(N-1)+1] = 1'b1; v[8*(N-1)+1] = ~rb[N-1];
    run_op(ra, rb, rc, rd, m, v, 2, 2, N-1, N-1, 1'b1, 1'b0, "R6 R7 a neg top");

    m = '0; v = '0; m[8*6+7] = 1'b1; v[8*6+7] = 1'b1;
    run_op(ra, rb, rc, rd, m, v, 2, 3, 0, 0, 1'b1, 1'b0, "R8 checker failure");

    m = '0; v = '0;
    m[8*0+0] = 1'b1; v[8*0+0] = 1'b0;
    m[8*5+0] = 1'b1; v[8*5+0] = 1'b1;
    run_op(ra, rb, rc, rd, m, v, 2, 4, 0, 0, 1'b0, 1'b0, "R9 multiple faults");

    m = '0; v = '0; m[8*1+4] = 1'b1; v[8*1+4] = ~ms[1];
    run_op(ra, rb, rc, rd, m, v, 2, 1, 1, 1, 1'b1, 1'b1, "R10 start while busy");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule